// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block sits next to a small 8-bit processor and decides, each time the chip leaves reset, whether the processor runs user code or a built-in debug monitor. It reads four things. The first is the two reset-vector bytes that the processor fetches right after reset is released. The second is a flag saying a test-level high voltage is present on the interrupt pin. The third is the logic level of that pin. The fourth is a flag saying the two port-A strap pins meet their start-up condition. It samples the pin inputs on the clock edge where the chip reset is released and holds them until the next reset.

If the reset vector has never been written (both bytes read as all ones) and the chip came up in user mode, the block requests one extra internal reset. It also sets a sticky forced-monitor latch. From then on every reset except a power-on reset brings the chip back up in monitor mode. A pulled external reset therefore does not leave that mode, and a second blank-vector reset is never issued. With a written vector, monitor mode needs the high-voltage flag and a valid strap condition at reset release.

In monitor mode the block has these effects:
- It clears address bit 8 on vector fetches, which moves the reset, software-interrupt and break vectors from page 0xFF to page 0xFE.
- It masks the interrupt-pin bit of the port-A read data.
- It lets the interrupt-level branch instructions see the pin as enabled.
- It moves port-A pin 0 to the serial line. Port-A pin 5 becomes the clock input when the sampled pin level was high.
- It forces the remaining pins to plain inputs.

While the forced latch is set, the watchdog is disabled.

Top module: `monitor_entry_unit`

## Requirements
- R1: While power-on reset (porRstN low, asynchronous) is applied and after it, until the first release of chipRstN, monMode, forcedMon, intRstReq and copDisable are all 0.
- R2: On the clock edge where chipRstN is first seen high after being low, monMode is set to 1 if hvIrq and strapOk are both 1 and the forced latch is clear. It is 0 if either of them is 0 and the latch is clear. The new value is visible after that edge.
- R3: After reset release, the first vector byte is presented with vecValid=1, vecIdx=0, and the second with vecValid=1, vecIdx=1. If both equal 0xFF in user mode, forcedMon and intRstReq become 1 on the edge that takes the second byte. intRstReq stays 1 until an edge where chipRstN is 0 clears it.
- R4: If only one of the two vector bytes is 0xFF, no internal reset is requested and forcedMon stays 0.
- R5: While forcedMon is 1, every release of chipRstN sets monMode to 1, whatever the values of hvIrq and strapOk. Cycles of chipRstN never clear forcedMon.
- R6: At most one internal reset is requested per power-on. Blank vectors seen while forcedMon is 1 request nothing.
- R7: copDisable is 1 exactly while forcedMon is 1.
- R8: When monMode=1 and vecAccess=1, addrOut equals addrIn with bit 8 cleared. Otherwise addrOut equals addrIn.
- R9: When monMode=1, bit 2 of portDataOut reads 0. Otherwise portDataOut equals portDataIn.
- R10: serialSel and forceIn equal monMode. clkSel equals monMode AND the irqLevel sampled at reset release. Changes of irqLevel after the release do not affect clkSel.
- R11: irqBranchEn is 1 when cfgIrqEn is 1 or monMode is 1.
- R12: Power-on reset clears forcedMon and re-arms the blank-vector check, so a later blank vector requests an internal reset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| chipRstN | input | 1 | Combined chip reset (any source), active low, sampled |
| hvIrq | input | 1 | Test high voltage present on interrupt pin |
| irqLevel | input | 1 | Logic level of interrupt pin |
| strapOk | input | 1 | Port-A strap pins meet start-up condition |
| vecValid | input | 1 | A reset-vector byte is on vecData |
| vecIdx | input | 1 | 0 = first vector byte, 1 = second |
| vecData | input | 8 | Fetched vector byte |
| vecAccess | input | 1 | Current bus access is a vector fetch |
| addrIn | input | 16 | Processor address |
| portDataIn | input | 8 | Raw port-A read data |
| cfgIrqEn | input | 1 | Configuration-register interrupt pin enable |
| addrOut | output | 16 | Address after vector-page remap |
| portDataOut | output | 8 | Port-A read data after masking |
| monMode | output | 1 | Monitor mode active |
| forcedMon | output | 1 | Sticky forced-monitor latch |
| intRstReq | output | 1 | Internal reset request |
| copDisable | output | 1 | Watchdog disable |
| serialSel | output | 1 | Port-A pin 0 is the serial line |
| clkSel | output | 1 | Port-A pin 5 is the clock input |
| forceIn | output | 1 | Remaining pins forced to plain inputs |
| irqBranchEn | output | 1 | Interrupt pin seen as enabled by level branches |

## Verification
A wrong mode latch is visible at the ports in the first cycle after reset release: monMode and the pin selects change together, so the address remap and port mask go wrong on the first vector fetch. A wrong forced latch or one-shot shows up one cycle after the second vector byte, as a missing or repeated intRstReq. It then persists across the following chipRstN cycles, and the bench compares monMode after each of them. Only power-on reset may bring it back, which the bench checks by seeing a fresh request after a power-on.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic sampleMode;  // reset release edge: sample pin inputs
    logic takeHi;      // first vector byte present
    logic takeLo;      // second vector byte present
    logic clrReq;      // chip reset low: drop internal request
  } monStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_DONE
  } fetchState_t;

endpackage

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       chipRstN,
  input  logic       vecValid,
  input  logic       vecIdx,
  output monStrobe_t strobe
);

  logic        prevRstN;
  fetchState_t state;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      prevRstN <= 1'b0;
      state    <= ST_IDLE;
    end else begin
      prevRstN <= chipRstN;
      if (!chipRstN) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE:    if (!prevRstN) state <= ST_WAIT_HI;
          ST_WAIT_HI: if (vecValid && !vecIdx) state <= ST_WAIT_LO;
          ST_WAIT_LO: if (vecValid && vecIdx) state <= ST_DONE;
          ST_DONE:    state <= ST_DONE;
          default:    state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.sampleMode = chipRstN && !prevRstN;
    strobe.takeHi     = (state == ST_WAIT_HI) && vecValid && !vecIdx;
    strobe.takeLo     = (state == ST_WAIT_LO) && vecValid && vecIdx;
    strobe.clrReq     = !chipRstN;
  end

endmodule

// File: rtl/mon_entry_dp.sv
module mon_entry_dp
  import mon_entry_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int PORT_W    = 8,
  parameter int REMAP_BIT = 8,
  parameter int IRQ_BIT   = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  monStrobe_t        strobe,
  input  logic              hvIrq,
  input  logic              irqLevel,
  input  logic              strapOk,
  input  logic [DATA_W-1:0] vecData,
  input  logic              vecAccess,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [PORT_W-1:0] portDataIn,
  input  logic              cfgIrqEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [PORT_W-1:0] portDataOut,
  output logic              monMode,
  output logic              forcedMon,
  output logic              intRstReq,
  output logic              copDisable,
  output logic              serialSel,
  output logic              clkSel,
  output logic              forceIn,
  output logic              irqBranchEn
);

  localparam logic [DATA_W-1:0] BLANK_BYTE = '1;
  localparam logic [ADDR_W-1:0] REMAP_MASK = ADDR_W'(1) << REMAP_BIT;
  localparam logic [PORT_W-1:0] IRQ_MASK   = PORT_W'(1) << IRQ_BIT;

  logic lvlQ;
  logic hiBlank;
  logic lowBlank;
  logic blankHit;

  assign lowBlank = (vecData == BLANK_BYTE);
  // The forced latch doubles as the one-shot guard.
  assign blankHit = strobe.takeLo && hiBlank && lowBlank && !forcedMon && !monMode;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      monMode   <= 1'b0;
      forcedMon <= 1'b0;
      intRstReq <= 1'b0;
      lvlQ      <= 1'b0;
      hiBlank   <= 1'b0;
    end else begin
      if (strobe.sampleMode) begin
        monMode <= forcedMon || (hvIrq && strapOk);
        lvlQ    <= irqLevel;
        hiBlank <= 1'b0;
      end
      if (strobe.takeHi) hiBlank <= lowBlank;
      if (strobe.clrReq) begin
        intRstReq <= 1'b0;
      end else if (blankHit) begin
        intRstReq <= 1'b1;
        forcedMon <= 1'b1;
      end
    end
  end

  logic remapNow;
  assign remapNow = monMode && vecAccess;

  always_comb begin
    addrOut     = remapNow ? (addrIn & ~REMAP_MASK) : addrIn;
    portDataOut = monMode ? (portDataIn & ~IRQ_MASK) : portDataIn;
    copDisable  = forcedMon;
    serialSel   = monMode;
    clkSel      = monMode && lvlQ;
    forceIn     = monMode;
    irqBranchEn = cfgIrqEn || monMode;
  end

endmodule

// File: rtl/monitor_entry_unit.sv
module monitor_entry_unit
  import mon_entry_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int PORT_W    = 8,
  parameter int REMAP_BIT = 8,
  parameter int IRQ_BIT   = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              chipRstN,
  input  logic              hvIrq,
  input  logic              irqLevel,
  input  logic              strapOk,
  input  logic              vecValid,
  input  logic              vecIdx,
  input  logic [DATA_W-1:0] vecData,
  input  logic              vecAccess,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [PORT_W-1:0] portDataIn,
  input  logic              cfgIrqEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [PORT_W-1:0] portDataOut,
  output logic              monMode,
  output logic              forcedMon,
  output logic              intRstReq,
  output logic              copDisable,
  output logic              serialSel,
  output logic              clkSel,
  output logic              forceIn,
  output logic              irqBranchEn
);

  monStrobe_t strobe;

  mon_entry_ctrl u_ctrl (
    .clk      (clk),
    .porRstN  (porRstN),
    .chipRstN (chipRstN),
    .vecValid (vecValid),
    .vecIdx   (vecIdx),
    .strobe   (strobe)
  );

  mon_entry_dp #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PORT_W    (PORT_W),
    .REMAP_BIT (REMAP_BIT),
    .IRQ_BIT   (IRQ_BIT)
  ) u_dp (
    .clk         (clk),
    .porRstN     (porRstN),
    .strobe      (strobe),
    .hvIrq       (hvIrq),
    .irqLevel    (irqLevel),
    .strapOk     (strapOk),
    .vecData     (vecData),
    .vecAccess   (vecAccess),
    .addrIn      (addrIn),
    .portDataIn  (portDataIn),
    .cfgIrqEn    (cfgIrqEn),
    .addrOut     (addrOut),
    .portDataOut (portDataOut),
    .monMode     (monMode),
    .forcedMon   (forcedMon),
    .intRstReq   (intRstReq),
    .copDisable  (copDisable),
    .serialSel   (serialSel),
    .clkSel      (clkSel),
    .forceIn     (forceIn),
    .irqBranchEn (irqBranchEn)
  );

endmodule

// File: rtl/monitor_entry_chk.sv
module monitor_entry_chk (
  input logic clk,
  input logic porRstN,
  input logic chipRstN,
  input logic vecAccess,
  input logic remapBit,
  input logic portIrqBit,
  input logic monMode,
  input logic forcedMon,
  input logic intRstReq
);

  AST_FORCED_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    !$fell(forcedMon)); // R5

  AST_FORCED_REENTRY: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(chipRstN) && forcedMon |=> monMode); // R5

  AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!porRstN)
    !chipRstN |=> !intRstReq); // R3

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(intRstReq) |-> !$past(forcedMon)); // R6

  AST_REMAP_LOW: assert property (@(posedge clk) disable iff (!porRstN)
    monMode && vecAccess |-> !remapBit); // R8

  AST_PORT_MASK: assert property (@(posedge clk) disable iff (!porRstN)
    monMode |-> !portIrqBit); // R9

endmodule

bind monitor_entry_unit monitor_entry_chk u_chk (
  .clk        (clk),
  .porRstN    (porRstN),
  .chipRstN   (chipRstN),
  .vecAccess  (vecAccess),
  .remapBit   (addrOut[REMAP_BIT]),
  .portIrqBit (portDataOut[IRQ_BIT]),
  .monMode    (monMode),
  .forcedMon  (forcedMon),
  .intRstReq  (intRstReq)
);

// File: tb/sim_monitor_entry_unit.sv
`timescale 1ns/1ps
module sim_monitor_entry_unit;

  localparam int SEL_MON = 0, SEL_FRC = 1, SEL_REQ = 2, SEL_COP = 3, SEL_SER = 4,
                 SEL_CLK = 5, SEL_FIN = 6, SEL_ADDR = 7, SEL_PORT = 8, SEL_BR = 9;

  typedef struct {
    string       tag;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  int    nRun = 0;
  int    nFail = 0;
  bit    done = 0;

  logic        clk = 0;
  logic        porRstN = 0, chipRstN = 0;
  logic        hvIrq = 0, irqLevel = 0, strapOk = 0;
  logic        vecValid = 0, vecIdx = 0;
  logic [7:0]  vecData = 0;
  logic        vecAccess = 0;
  logic [15:0] addrIn = 0;
  logic [7:0]  portDataIn = 0;
  logic        cfgIrqEn = 0;
  logic [15:0] addrOut;
  logic [7:0]  portDataOut;
  logic        monMode, forcedMon, intRstReq, copDisable;
  logic        serialSel, clkSel, forceIn, irqBranchEn;

  always #4 clk = ~clk;  // 125 MHz

  monitor_entry_unit u0 (
    .clk(clk), .porRstN(porRstN), .chipRstN(chipRstN), .hvIrq(hvIrq),
    .irqLevel(irqLevel), .strapOk(strapOk), .vecValid(vecValid), .vecIdx(vecIdx),
    .vecData(vecData), .vecAccess(vecAccess), .addrIn(addrIn),
    .portDataIn(portDataIn), .cfgIrqEn(cfgIrqEn), .addrOut(addrOut),
    .portDataOut(portDataOut), .monMode(monMode), .forcedMon(forcedMon),
    .intRstReq(intRstReq), .copDisable(copDisable), .serialSel(serialSel),
    .clkSel(clkSel), .forceIn(forceIn), .irqBranchEn(irqBranchEn)
  );

  function automatic logic [15:0] actual(int sel);
    case (sel)
      SEL_MON:  return {15'd0, monMode};
      SEL_FRC:  return {15'd0, forcedMon};
      SEL_REQ:  return {15'd0, intRstReq};
      SEL_COP:  return {15'd0, copDisable};
      SEL_SER:  return {15'd0, serialSel};
      SEL_CLK:  return {15'd0, clkSel};
      SEL_FIN:  return {15'd0, forceIn};
      SEL_ADDR: return addrOut;
      SEL_PORT: return {8'd0, portDataOut};
      default:  return {15'd0, irqBranchEn};
    endcase
  endfunction

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      nRun++;
      if (actual(it.sel) !== it.exp) begin
        nFail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, actual(it.sel), it.exp);
      end
    end
  end

  task automatic expect1(string tag, int sel, logic [15:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // Release chip reset with given pin inputs; mode visible after one edge.
  task automatic release_rst(logic hv, logic lvl, logic strap);
    chipRstN = 0; hvIrq = hv; irqLevel = lvl; strapOk = strap;
    cyc(); cyc();
    chipRstN = 1;
    cyc();
  endtask

  task automatic fetch_vec(logic [7:0] b0, logic [7:0] b1);
    vecValid = 1; vecIdx = 0; vecData = b0;
    cyc();
    vecIdx = 1; vecData = b1;
    cyc();
    vecValid = 0; vecData = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : driver
    // Power-on
    cyc(); cyc();
    expect1("R1", SEL_MON, 0); expect1("R1", SEL_FRC, 0);
    expect1("R1", SEL_REQ, 0); expect1("R1", SEL_COP, 0);
    cyc();
    porRstN = 1;
    cyc();
    expect1("R1", SEL_MON, 0); expect1("R1", SEL_REQ, 0);
    cyc();

    // User mode: no high voltage
    release_rst(0, 1, 1);
    expect1("R2", SEL_MON, 0); expect1("R10", SEL_SER, 0); expect1("R10", SEL_CLK, 0);
    vecAccess = 1; addrIn = 16'hFFFE; portDataIn = 8'hFF; cfgIrqEn = 0;
    expect1("R8", SEL_ADDR, 16'hFFFE); expect1("R9", SEL_PORT, 16'h00FF);
    expect1("R11", SEL_BR, 0);
    cyc();
    cfgIrqEn = 1;
    expect1("R11", SEL_BR, 1);
    cyc();
    cfgIrqEn = 0; vecAccess = 0;
    fetch_vec(8'h12, 8'hFF);
    expect1("R4", SEL_REQ, 0); expect1("R4", SEL_FRC, 0);
    cyc();

    // High voltage without strap condition: user mode
    release_rst(1, 1, 0);
    expect1("R2", SEL_MON, 0);
    fetch_vec(8'hFF, 8'h00);
    expect1("R4", SEL_REQ, 0);
    cyc();

    // High-voltage monitor mode
    release_rst(1, 1, 1);
    expect1("R2", SEL_MON, 1); expect1("R2", SEL_FRC, 0); expect1("R7", SEL_COP, 0);
    expect1("R10", SEL_SER, 1); expect1("R10", SEL_CLK, 1); expect1("R10", SEL_FIN, 1);
    expect1("R11", SEL_BR, 1);
    cyc();
    irqLevel = 0; hvIrq = 0;
    vecAccess = 1; addrIn = 16'hFFFE; portDataIn = 8'hFF;
    expect1("R10", SEL_CLK, 1);
    expect1("R8", SEL_ADDR, 16'hFEFE); expect1("R9", SEL_PORT, 16'h00FB);
    cyc();
    vecAccess = 0;
    expect1("R8", SEL_ADDR, 16'hFFFE);
    cyc();

    // Blank vector in user mode
    release_rst(0, 0, 0);
    expect1("R2", SEL_MON, 0);
    fetch_vec(8'hFF, 8'hFF);
    expect1("R3", SEL_REQ, 1); expect1("R3", SEL_FRC, 1); expect1("R7", SEL_COP, 1);
    cyc();
    expect1("R3", SEL_REQ, 1);
    chipRstN = 0;
    cyc();
    expect1("R3", SEL_REQ, 0); expect1("R5", SEL_FRC, 1);
    cyc();
    chipRstN = 1;
    cyc();
    expect1("R5", SEL_MON, 1); expect1("R10", SEL_CLK, 0); expect1("R10", SEL_SER, 1);
    cyc();

    // Blank again: no second request
    fetch_vec(8'hFF, 8'hFF);
    expect1("R6", SEL_REQ, 0);
    cyc();

    // External reset cycle stays in forced monitor
    release_rst(0, 1, 1);
    expect1("R5", SEL_MON, 1); expect1("R5", SEL_FRC, 1); expect1("R10", SEL_CLK, 1);
    cyc();

    // Power-on clears and re-arms
    porRstN = 0;
    cyc();
    expect1("R12", SEL_FRC, 0); expect1("R12", SEL_MON, 0); expect1("R7", SEL_COP, 0);
    cyc();
    porRstN = 1;
    release_rst(0, 0, 0);
    expect1("R12", SEL_MON, 0);
    fetch_vec(8'hFF, 8'hFF);
    expect1("R12", SEL_REQ, 1); expect1("R12", SEL_FRC, 1);
    cyc(); cyc();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule